// File: doc/BRIEF.md
# Bus Turnaround Reset Sequencer

This block steps a bidirectional byte lane through a change of bus direction, clocked by the control clock. A single-cycle start request opens a fixed sequence. First the strobe-path gate clear is pulsed for one cycle and then dropped. While that happens, the read and write enables that normally pass straight through from the user side are held at zero. Next the lane reset is asserted for a hold time set by the configured data width. When the reset is released, the enables go back to user control and transmit is allowed at once. Receive is reported ready only when the lane's FIFO-empty flag first falls after that release.

A per-lane mask is captured at the start request, and only unmasked lanes get the reset. While a lane is in reset, its transmit output shows the lane's configured initial level in place of the user data. The hold time is counted in control-clock cycles. It is one cycle plus the number of fast-clock cycles the width requires, divided by a fast-to-control clock ratio and rounded up. If transmit and receive widths differ, the wider one sets the hold.

Top module: `lane_turnaround_seq`

## Requirements
- R1: After an accepted start, `gate_clr_o` is high for exactly one cycle, followed by one cycle with it low, followed by the first reset cycle. Neither the gate clear nor the reset is ever asserted in any other order.
- R2: From the gate-clear cycle through the last reset cycle, `rden_o` and `wren_o` are all zeros. In every other cycle they equal `rden_user_i` and `wren_user_i`.
- R3: The reset lasts 1 + ceil(F / FAST_RATIO) cycles. F is 24 for width code 2'b00, 40 for 2'b01, and 72 for 2'b10 or 2'b11. With the default ratio of 1 this gives 25, 41 and 73 cycles.
- R4: The width code of higher rank (00 < 01 < 10 = 11) among `tx_width_i` and `rx_width_i`, sampled with the start, selects F.
- R5: `lane_mask_i` is captured with the start. During reset, `lane_rst_o[i]` is 1 only where the captured mask bit is 0.
- R6: `tx_pad_o[i]` equals `tx_init_i[i]` while `lane_rst_o[i]` is 1, and equals `tx_data_i[i]` otherwise.
- R7: `tx_ok_o` resets to 0 and falls in the cycle after an accepted start. It rises in the cycle after the last reset cycle.
- R8: `rx_ok_o` resets to 0 and is cleared by an accepted start. After the release it rises one cycle after the first clock edge at which `fifo_empty_i` is 0, provided it was 1 at the edge before.
- R9: `busy_o` is high from the cycle after an accepted start through the last reset cycle. A start while busy changes neither the hold time nor the captured mask.
- R10: `done_o` is a one-cycle pulse in the cycle after the last reset cycle, which is the cycle in which the enables return to user control.
- R11: After reset all outputs are 0, except that the enables follow the user inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Turnaround request, sampled when idle |
| tx_width_i | input | 2 | Transmit width code |
| rx_width_i | input | 2 | Receive width code |
| lane_mask_i | input | LANES | 1 excludes a lane from the reset |
| rden_user_i | input | EN_W | User read enables |
| wren_user_i | input | EN_W | User write enables |
| fifo_empty_i | input | 1 | Receive FIFO empty flag |
| tx_init_i | input | LANES | Per-lane transmit level during reset |
| tx_data_i | input | LANES | Per-lane transmit data |
| gate_clr_o | output | 1 | Strobe gate clear pulse |
| lane_rst_o | output | LANES | Per-lane reset |
| tx_pad_o | output | LANES | Per-lane transmit output |
| rden_o | output | EN_W | Read enables to the lane |
| wren_o | output | EN_W | Write enables to the lane |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Enables released pulse |
| tx_ok_o | output | 1 | Transmit permitted |
| rx_ok_o | output | 1 | Receive data valid |

## Verification
Once a start is sampled at a clock edge, the gate clear shows one cycle later, the clear-low cycle follows it, and the reset begins two cycles after the start. The release, `done_o` and `tx_ok_o` come 2 + hold cycles after the start. `rx_ok_o` comes one cycle after the edge that sees the FIFO-empty fall. The pass-through enables and the pad multiplexer respond within the same cycle. The bench drives inputs on the falling edge and runs a step-count reference model on the rising edge. It compares every output a quarter period before the next rising edge, so registered and same-cycle results are both sampled where they are due. Separate directed checks measure the busy length against the expected hold for each width pair.

// File: rtl/lts_pkg.sv
package lts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GCLR  = 2'd1,
        ST_GOPEN = 2'd2,
        ST_HOLD  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic gate_clr;
        logic lane_hold;
        logic busy;
        logic done;
        logic start_acc;
        logic release_evt;
    } seq_ctl_t;

    localparam int unsigned FAST_W2 = 24;
    localparam int unsigned FAST_W4 = 40;
    localparam int unsigned FAST_W8 = 72;

    function automatic int unsigned width_rank(input logic [1:0] code);
        if (code[1])      return 2;
        else if (code[0]) return 1;
        else              return 0;
    endfunction

    function automatic logic [1:0] wider_code(input logic [1:0] a, input logic [1:0] b);
        return (width_rank(a) >= width_rank(b)) ? a : b;
    endfunction

    function automatic int unsigned fast_cycles(input logic [1:0] code);
        if (code[1])      return FAST_W8;
        else if (code[0]) return FAST_W4;
        else              return FAST_W2;
    endfunction

    function automatic int unsigned hold_cycles(input logic [1:0] code, input int unsigned ratio);
        return 1 + (fast_cycles(code) + ratio - 1) / ratio;
    endfunction

endpackage

// File: rtl/lts_seq_fsm.sv
module lts_seq_fsm
    import lts_pkg::*;
#(
    parameter int unsigned FAST_RATIO = 1,
    parameter int unsigned LANES      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       tx_width_i,
    input  logic [1:0]       rx_width_i,
    input  logic [LANES-1:0] mask_i,
    output seq_ctl_t         ctl_o,
    output logic [LANES-1:0] mask_o
);
    localparam int unsigned MAX_HOLD = 1 + (FAST_W8 + FAST_RATIO - 1) / FAST_RATIO;
    localparam int unsigned CNT_W    = $clog2(MAX_HOLD + 1);

    seq_state_e         state;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   hold_q;
    logic [CNT_W-1:0]   hold_d;
    logic [LANES-1:0]   mask_q;
    logic               done_q;

    assign hold_d = CNT_W'(hold_cycles(wider_code(tx_width_i, rx_width_i), FAST_RATIO));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            hold_q <= '0;
            mask_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state  <= ST_GCLR;
                        hold_q <= hold_d;
                        mask_q <= mask_i;
                    end
                end
                ST_GCLR:  state <= ST_GOPEN;
                ST_GOPEN: begin
                    state <= ST_HOLD;
                    cnt   <= hold_q - 1'b1;
                end
                ST_HOLD: begin
                    if (cnt == '0) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ctl_o.gate_clr    = (state == ST_GCLR);
        ctl_o.lane_hold   = (state == ST_HOLD);
        ctl_o.busy        = (state != ST_IDLE);
        ctl_o.done        = done_q;
        ctl_o.start_acc   = (state == ST_IDLE) && start_i;
        ctl_o.release_evt = (state == ST_HOLD) && (cnt == '0);
    end

    assign mask_o = mask_q;

    // Independent count of cycles spent in reset, for the hold-length check.
    logic [CNT_W:0] chk_n;
    always_ff @(posedge clk) begin
        if (rst)                    chk_n <= '0;
        else if (state == ST_HOLD)  chk_n <= chk_n + 1'b1;
        else                        chk_n <= '0;
    end

    p_order_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && $past(state) != ST_HOLD) |-> $past(state) == ST_GOPEN);

    p_order_open_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GOPEN) |-> $past(state) == ST_GCLR);

    p_hold_len_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && cnt == '0) |-> (chk_n + 1'b1) == {1'b0, hold_q});

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start_i) |=> ($stable(hold_q) && $stable(mask_q)));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/lts_rx_track.sv
module lts_rx_track (
    input  logic clk,
    input  logic rst,
    input  logic start_acc_i,
    input  logic release_i,
    input  logic fifo_empty_i,
    output logic rx_ok_o
);
    logic armed;
    logic empty_q;
    logic ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            empty_q <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            empty_q <= fifo_empty_i;
            if (start_acc_i) begin
                armed <= 1'b0;
                ok_q  <= 1'b0;
            end else begin
                if (armed && empty_q && !fifo_empty_i) begin
                    ok_q  <= 1'b1;
                    armed <= 1'b0;
                end
                if (release_i) armed <= 1'b1;
            end
        end
    end

    assign rx_ok_o = ok_q;

    p_rx_first_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ok_q) |-> ($past(empty_q) && !$past(fifo_empty_i)));

endmodule

// File: rtl/lts_lane_drive.sv
module lts_lane_drive #(
    parameter int unsigned LANES = 6
) (
    input  logic             hold_i,
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] init_i,
    input  logic [LANES-1:0] data_i,
    output logic [LANES-1:0] lane_rst_o,
    output logic [LANES-1:0] pad_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic in_rst;
        assign in_rst        = hold_i && !mask_i[g];
        assign lane_rst_o[g] = in_rst;
        assign pad_o[g]      = in_rst ? init_i[g] : data_i[g];

        always_comb begin
            a_pad_init_r6: assert (!in_rst || pad_o[g] == init_i[g]);
        end
    end
endmodule

// File: rtl/lane_turnaround_seq.sv
module lane_turnaround_seq
    import lts_pkg::*;
#(
    parameter int unsigned FAST_RATIO = 1,
    parameter int unsigned LANES      = 6,
    parameter int unsigned EN_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       tx_width_i,
    input  logic [1:0]       rx_width_i,
    input  logic [LANES-1:0] lane_mask_i,
    input  logic [EN_W-1:0]  rden_user_i,
    input  logic [EN_W-1:0]  wren_user_i,
    input  logic             fifo_empty_i,
    input  logic [LANES-1:0] tx_init_i,
    input  logic [LANES-1:0] tx_data_i,
    output logic             gate_clr_o,
    output logic [LANES-1:0] lane_rst_o,
    output logic [LANES-1:0] tx_pad_o,
    output logic [EN_W-1:0]  rden_o,
    output logic [EN_W-1:0]  wren_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             tx_ok_o,
    output logic             rx_ok_o
);
    seq_ctl_t         ctl;
    logic [LANES-1:0] mask_q;
    logic             tx_ok_q;

    lts_seq_fsm #(.FAST_RATIO(FAST_RATIO), .LANES(LANES)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .tx_width_i (tx_width_i),
        .rx_width_i (rx_width_i),
        .mask_i     (lane_mask_i),
        .ctl_o      (ctl),
        .mask_o     (mask_q)
    );

    lts_rx_track u_rx (
        .clk          (clk),
        .rst          (rst),
        .start_acc_i  (ctl.start_acc),
        .release_i    (ctl.release_evt),
        .fifo_empty_i (fifo_empty_i),
        .rx_ok_o      (rx_ok_o)
    );

    lts_lane_drive #(.LANES(LANES)) u_lanes (
        .hold_i     (ctl.lane_hold),
        .mask_i     (mask_q),
        .init_i     (tx_init_i),
        .data_i     (tx_data_i),
        .lane_rst_o (lane_rst_o),
        .pad_o      (tx_pad_o)
    );

    always_ff @(posedge clk) begin
        if (rst)                  tx_ok_q <= 1'b0;
        else if (ctl.start_acc)   tx_ok_q <= 1'b0;
        else if (ctl.release_evt) tx_ok_q <= 1'b1;
    end

    assign rden_o     = ctl.busy ? '0 : rden_user_i;
    assign wren_o     = ctl.busy ? '0 : wren_user_i;
    assign gate_clr_o = ctl.gate_clr;
    assign busy_o     = ctl.busy;
    assign done_o     = ctl.done;
    assign tx_ok_o    = tx_ok_q;

    p_en_zero_in_rst_r2: assert property (@(posedge clk) disable iff (rst)
        (|lane_rst_o) |-> (rden_o == '0 && wren_o == '0));

    p_tx_ok_at_done_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> tx_ok_o);

    p_rst_masked_r5: assert property (@(posedge clk) disable iff (rst)
        ((lane_rst_o & mask_q) == '0));

endmodule

// File: tb/lane_turnaround_seq_bench.sv
module lane_turnaround_seq_bench;
    localparam int LANES = 6;
    localparam int EN_W  = 4;
    localparam int RATIO = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [1:0] tx_w = 2'b00, rx_w = 2'b00;
    logic [LANES-1:0] mask = '0;
    logic [EN_W-1:0] rden_u = '0, wren_u = '0;
    logic fifo_empty = 1'b0;
    logic [LANES-1:0] tinit = '0, tdata = '0;

    logic gate_clr, busy, done, tx_ok, rx_ok;
    logic [LANES-1:0] lane_rst, pad;
    logic [EN_W-1:0] rden, wren;

    always #10 clk = ~clk;

    lane_turnaround_seq #(.FAST_RATIO(RATIO), .LANES(LANES), .EN_W(EN_W)) u_lane_turnaround_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .tx_width_i(tx_w), .rx_width_i(rx_w),
        .lane_mask_i(mask), .rden_user_i(rden_u), .wren_user_i(wren_u),
        .fifo_empty_i(fifo_empty), .tx_init_i(tinit), .tx_data_i(tdata),
        .gate_clr_o(gate_clr), .lane_rst_o(lane_rst), .tx_pad_o(pad),
        .rden_o(rden), .wren_o(wren), .busy_o(busy), .done_o(done),
        .tx_ok_o(tx_ok), .rx_ok_o(rx_ok)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int rank(input logic [1:0] c);
        return c[1] ? 2 : (c[0] ? 1 : 0);
    endfunction

    function automatic int exp_hold(input logic [1:0] a, input logic [1:0] b);
        int r, f;
        r = (rank(a) > rank(b)) ? rank(a) : rank(b);
        f = (r == 2) ? 72 : ((r == 1) ? 40 : 24);
        return 1 + (f + RATIO - 1) / RATIO;
    endfunction

    // Behavioural reference: a step number since the accepted start.
    int m_seq = 0, m_hold = 0;
    bit m_done = 0, m_txok = 0, m_rxok = 0, m_armed = 0, m_prev_empty = 0;
    logic [LANES-1:0] m_mask = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_seq = 0; m_hold = 0; m_done = 0; m_txok = 0; m_rxok = 0;
            m_armed = 0; m_prev_empty = 0; m_mask = '0;
        end else begin
            m_done = 0;
            if (m_seq == 0 && start_i) begin
                m_rxok = 0; m_armed = 0;
            end else if (m_armed && m_prev_empty && !fifo_empty) begin
                m_rxok = 1; m_armed = 0;
            end
            if (m_seq == 0) begin
                if (start_i) begin
                    m_seq = 1; m_hold = exp_hold(tx_w, rx_w); m_mask = mask; m_txok = 0;
                end
            end else if (m_seq == 2 + m_hold) begin
                m_seq = 0; m_done = 1; m_txok = 1; m_armed = 1;
            end else begin
                m_seq++;
            end
            m_prev_empty = fifo_empty;
        end
    end

    // Every-cycle comparison, a quarter period before the rising edge.
    always @(negedge clk) begin
        #5;
        if (!rst && !finished) begin
            logic [LANES-1:0] e_rst, e_pad;
            bit in_r;
            in_r  = (m_seq >= 3);
            e_rst = in_r ? ~m_mask : '0;
            for (int i = 0; i < LANES; i++) e_pad[i] = e_rst[i] ? tinit[i] : tdata[i];
            chk(gate_clr == (m_seq == 1), "R1 gate_clr", gate_clr, m_seq == 1);
            chk(lane_rst == e_rst, "R3/R5 lane_rst", lane_rst, e_rst);
            chk(pad == e_pad, "R6 tx_pad", pad, e_pad);
            chk(rden == ((m_seq > 0) ? '0 : rden_u), "R2 rden", rden, (m_seq > 0) ? '0 : rden_u);
            chk(wren == ((m_seq > 0) ? '0 : wren_u), "R2 wren", wren, (m_seq > 0) ? '0 : wren_u);
            chk(busy == (m_seq > 0), "R9 busy", busy, m_seq > 0);
            chk(done == m_done, "R10 done", done, m_done);
            chk(tx_ok == m_txok, "R7 tx_ok", tx_ok, m_txok);
            chk(rx_ok == m_rxok, "R8 rx_ok", rx_ok, m_rxok);
        end
    end

    // Background user traffic on the pass-through inputs.
    int cyc = 0;
    always @(negedge clk) begin
        cyc++;
        rden_u <= cyc[3:0];
        wren_u <= ~cyc[4:1];
        tdata  <= cyc[LANES-1:0] ^ 6'b010101;
        tinit  <= {cyc[7:5], ~cyc[7:5]};
    end

    task automatic turnaround(input logic [1:0] tw, input logic [1:0] rw,
                              input logic [LANES-1:0] mk, input bit poke, input bit empty_low_at_release);
        int n, h;
        h = exp_hold(tw, rw);
        @(negedge clk);
        tx_w = tw; rx_w = rw; mask = mk; start_i = 1'b1;
        fifo_empty = empty_low_at_release ? 1'b0 : 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (busy) begin
            n++;
            if (poke && n == 5) begin
                start_i = 1'b1; tx_w = 2'b11; rx_w = 2'b11; mask = ~mk;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        // R3 R4 R9: busy length is two set-up cycles plus the hold.
        chk(n == 2 + h, "R3/R4 busy length", n, 2 + h);
        repeat (3) @(negedge clk);
        if (empty_low_at_release) begin
            chk(rx_ok == 1'b0, "R8 no fall yet", rx_ok, 0);
            fifo_empty = 1'b1;
            repeat (2) @(negedge clk);
        end
        fifo_empty = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_ok == 1'b1, "R8 rx_ok after fall", rx_ok, 1);
        chk(tx_ok == 1'b1, "R7 tx_ok held", tx_ok, 1);
        fifo_empty = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        // R11 reset state
        chk(busy == 0 && done == 0 && gate_clr == 0, "R11 ctl after reset", {busy, done, gate_clr}, 0);
        chk(lane_rst == '0 && tx_ok == 0 && rx_ok == 0, "R11 status after reset", {lane_rst, tx_ok, rx_ok}, 0);
        turnaround(2'b00, 2'b00, 6'b000000, 0, 0);
        turnaround(2'b01, 2'b00, 6'b100101, 1, 0);
        turnaround(2'b00, 2'b10, 6'b010010, 0, 1);
        turnaround(2'b11, 2'b01, 6'b111111, 1, 0);
        turnaround(2'b01, 2'b01, 6'b000011, 0, 1);
        // Back-to-back start right after a release.
        @(negedge clk);
        tx_w = 2'b00; rx_w = 2'b00; mask = '0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy == 1'b1 && tx_ok == 1'b0, "R7/R9 restart", {busy, tx_ok}, 2'b10);
        repeat (40) @(negedge clk);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule